// File: doc/BRIEF.md
# Monochrome Raster Scan Engine

This block produces the raster timing for a 640x480, 60 Hz analogue video monitor from a 25.2 MHz pixel clock. It also turns a one-bit-per-pixel image into colour signals. The image sits in a dual-port RAM as 16-bit words. This block uses only the read port; another agent writes the picture through the other port. Each word holds sixteen horizontally adjacent pixels. A line of 640 pixels is therefore 40 consecutive words, and the 480 lines fill 19200 words (307200 bits).

Two instances of one axis state machine sweep the beam. The horizontal machine advances on every clock. The vertical machine advances when a line ends. Each machine walks through the states `PH_VIS` → `PH_FRONT` → `PH_SYNC` → `PH_BACK` → `PH_VIS`. The transitions fire on:
- the last visible count (`VIS→FRONT`);
- the last front-porch count (`FRONT→SYNC`);
- the last sync count (`SYNC→BACK`);
- the last count of the period (`BACK→VIS`, where the counter also wraps).

A fetch unit reads the word for a group of sixteen pixels during the cycle in which the scan reaches the first pixel of that group. When the word returns, it loads a shift register that hands out one bit per clock. All sync, blanking and strobe signals pass through a delay line of the same length, so every port stays aligned to the pixel it describes. A one-cycle frame strobe marks the start of vertical blanking. Writers can use it to update or swap the picture while nothing is being displayed.

Top module: `mono_vga_scan`

## Requirements
- R1: A line lasts H_ACT+H_FP+H_SY+H_BP clocks (800 by default). On the port side, `hsync_n` is low for exactly the H_SY clocks that start H_ACT+H_FP clocks after the first visible pixel of the line.
- R2: A frame lasts V_ACT+V_FP+V_SY+V_BP lines (525 by default). `vsync_n` is low for exactly the V_SY whole lines that start V_ACT+V_FP lines after the first visible line.
- R3: `fb_rd_en` is high for exactly one clock per 16-pixel group of the visible area: the clock in which the scan counters point at column x with x mod WORD_W = 0. It is never high outside the visible area. In that clock, `fb_rd_addr` = row × (H_ACT/WORD_W) + x/WORD_W.
- R4: `fb_rd_data` is taken RD_LAT clocks after its request. Bit WORD_W-1 (the MSB) of a word is the leftmost pixel of its group, and lower bits follow to the right in order.
- R5: A pixel bit of 1 drives `red`, `green` and `blue` to all ones. A bit of 0 drives all three to zero.
- R6: Outside the visible 640x480 area, all three colour outputs are zero, whatever the RAM returns.
- R7: `frame_start` is high for exactly one clock per frame: the clock in which the ports describe column 0 of line V_ACT, the first line of vertical blanking.
- R8: All ports lag the scan counters by the same RD_LAT+1 clocks. Ports describe position (0,0) in the (RD_LAT+1)-th clock after reset is released.
- R9: While reset is high, and until R8's first position reaches the ports, both syncs are high, colours are zero and `frame_start` is low. Reset also restarts the scan at (0,0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| fb_rd_en | output | 1 | Framebuffer read request |
| fb_rd_addr | output | AW (15) | Framebuffer word address |
| fb_rd_data | input | WORD_W (16) | Framebuffer read data, valid RD_LAT clocks after request |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| red | output | COLOR_W (4) | Red channel |
| green | output | COLOR_W (4) | Green channel |
| blue | output | COLOR_W (4) | Blue channel |
| frame_start | output | 1 | One-clock strobe at the start of vertical blanking |

## Verification
A wrong state transition or counter wrap moves a sync edge. The bench sees this on `hsync_n` within the same line, and on `vsync_n` or `frame_start` within one frame. A wrong delay in the fetch or load path shifts the picture by whole pixels, or swaps bits within a word. A pseudo-random image exposes this on the colour outputs at the first visible group of the first line. An address error shows up on `fb_rd_addr` in the very clock of the request.

// File: rtl/mvga_pkg.sv
package mvga_pkg;

    // Phase of one scan axis; order of the encoding is the order of traversal.
    typedef enum logic [1:0] {
        PH_VIS   = 2'd0,
        PH_FRONT = 2'd1,
        PH_SYNC  = 2'd2,
        PH_BACK  = 2'd3
    } phase_t;

    // Control bits that travel alongside a pixel through the fetch delay.
    typedef struct packed {
        logic hs_n;
        logic vs_n;
        logic vis;
        logic fstart;
    } scan_ctl_t;

    localparam scan_ctl_t CTL_IDLE = '{hs_n: 1'b1, vs_n: 1'b1, vis: 1'b0, fstart: 1'b0};

endpackage

// File: rtl/mvga_axis.sv
module mvga_axis
    import mvga_pkg::*;
#(
    parameter int ACT = 640,
    parameter int FP  = 16,
    parameter int SY  = 96,
    parameter int BP  = 48,
    localparam int TOT = ACT + FP + SY + BP,
    localparam int CW  = $clog2(TOT)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    output logic [CW-1:0] cnt,
    output phase_t        phase,
    output logic          sync_n,
    output logic          in_vis
);

    localparam logic [CW-1:0] LAST_VIS   = CW'(ACT - 1);
    localparam logic [CW-1:0] LAST_FRONT = CW'(ACT + FP - 1);
    localparam logic [CW-1:0] LAST_SYNC  = CW'(ACT + FP + SY - 1);
    localparam logic [CW-1:0] LAST_ALL   = CW'(TOT - 1);

    phase_t phase_nx;
    logic   wrap;

    always_comb wrap = (cnt == LAST_ALL);

    // position counter
    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (step)
            cnt <= wrap ? '0 : cnt + CW'(1);
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst)
            phase <= PH_VIS;
        else if (step)
            phase <= phase_nx;
    end

    // next state
    always_comb begin
        phase_nx = phase;
        unique case (phase)
            PH_VIS:   if (cnt == LAST_VIS)   phase_nx = PH_FRONT;
            PH_FRONT: if (cnt == LAST_FRONT) phase_nx = PH_SYNC;
            PH_SYNC:  if (cnt == LAST_SYNC)  phase_nx = PH_BACK;
            PH_BACK:  if (wrap)              phase_nx = PH_VIS;
        endcase
    end

    // outputs
    always_comb begin
        sync_n = (phase != PH_SYNC);
        in_vis = (phase == PH_VIS);
    end

endmodule

// File: rtl/mvga_fetch.sv
module mvga_fetch #(
    parameter int WORD_W = 16,
    parameter int RD_LAT = 1,
    parameter int WPL    = 40,
    parameter int AW     = 15,
    parameter int HCW    = 10,
    parameter int VCW    = 10,
    localparam int LOG2W = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [HCW-1:0]    hc,
    input  logic [VCW-1:0]    vc,
    input  logic              visible,
    output logic              rd_en,
    output logic [AW-1:0]     rd_addr,
    input  logic [WORD_W-1:0] rd_data,
    output logic              pix_bit
);

    logic [RD_LAT-1:0] ld_pipe;
    logic              loaded;
    logic [WORD_W-1:0] shreg;

    // request on the first pixel of every group
    always_comb begin
        rd_en   = visible && (hc[LOG2W-1:0] == '0);
        rd_addr = AW'(vc) * AW'(WPL) + AW'(hc >> LOG2W);
    end

    // track when each requested word comes back
    always_ff @(posedge clk) begin
        if (rst) begin
            ld_pipe <= '0;
        end else begin
            ld_pipe[0] <= rd_en;
            for (int i = 1; i < RD_LAT; i++)
                ld_pipe[i] <= ld_pipe[i-1];
        end
    end

    always_comb loaded = ld_pipe[RD_LAT-1];

    // returning word: MSB is shown at once, the rest shifts up
    always_ff @(posedge clk) begin
        if (rst)
            shreg <= '0;
        else if (loaded)
            shreg <= rd_data << 1;
        else
            shreg <= shreg << 1;
    end

    always_comb pix_bit = loaded ? rd_data[WORD_W-1] : shreg[WORD_W-1];

endmodule

// File: rtl/mono_vga_scan.sv
module mono_vga_scan
    import mvga_pkg::*;
#(
    parameter int H_ACT   = 640,
    parameter int H_FP    = 16,
    parameter int H_SY    = 96,
    parameter int H_BP    = 48,
    parameter int V_ACT   = 480,
    parameter int V_FP    = 10,
    parameter int V_SY    = 2,
    parameter int V_BP    = 33,
    parameter int WORD_W  = 16,
    parameter int RD_LAT  = 1,
    parameter int COLOR_W = 4,
    localparam int H_TOT  = H_ACT + H_FP + H_SY + H_BP,
    localparam int V_TOT  = V_ACT + V_FP + V_SY + V_BP,
    localparam int HCW    = $clog2(H_TOT),
    localparam int VCW    = $clog2(V_TOT),
    localparam int WPL    = H_ACT / WORD_W,
    localparam int WORDS  = WPL * V_ACT,
    localparam int AW     = $clog2(WORDS)
) (
    input  logic               clk,
    input  logic               rst,
    output logic               fb_rd_en,
    output logic [AW-1:0]      fb_rd_addr,
    input  logic [WORD_W-1:0]  fb_rd_data,
    output logic               hsync_n,
    output logic               vsync_n,
    output logic [COLOR_W-1:0] red,
    output logic [COLOR_W-1:0] green,
    output logic [COLOR_W-1:0] blue,
    output logic               frame_start
);

    logic [HCW-1:0] hc;
    logic [VCW-1:0] vc;
    phase_t         h_ph;
    phase_t         v_ph;
    logic           h_sync_n;
    logic           v_sync_n;
    logic           h_vis;
    logic           v_vis;
    logic           h_wrap;
    logic           pix_bit;
    logic           out_vis;
    scan_ctl_t      ctl_now;
    scan_ctl_t      ctl_pipe [RD_LAT];
    scan_ctl_t      ctl_at;

    always_comb h_wrap = (h_ph == PH_BACK) && (hc == HCW'(H_TOT - 1));

    mvga_axis #(
        .ACT(H_ACT), .FP(H_FP), .SY(H_SY), .BP(H_BP)
    ) u_haxis (
        .clk(clk), .rst(rst), .step(1'b1),
        .cnt(hc), .phase(h_ph), .sync_n(h_sync_n), .in_vis(h_vis)
    );

    mvga_axis #(
        .ACT(V_ACT), .FP(V_FP), .SY(V_SY), .BP(V_BP)
    ) u_vaxis (
        .clk(clk), .rst(rst), .step(h_wrap),
        .cnt(vc), .phase(v_ph), .sync_n(v_sync_n), .in_vis(v_vis)
    );

    mvga_fetch #(
        .WORD_W(WORD_W), .RD_LAT(RD_LAT), .WPL(WPL),
        .AW(AW), .HCW(HCW), .VCW(VCW)
    ) u_fetch (
        .clk(clk), .rst(rst),
        .hc(hc), .vc(vc), .visible(h_vis && v_vis),
        .rd_en(fb_rd_en), .rd_addr(fb_rd_addr), .rd_data(fb_rd_data),
        .pix_bit(pix_bit)
    );

    // control bits for the position the counters hold now
    always_comb begin
        ctl_now.hs_n   = h_sync_n;
        ctl_now.vs_n   = v_sync_n;
        ctl_now.vis    = h_vis && v_vis;
        ctl_now.fstart = (hc == '0) && (v_ph == PH_FRONT) && (vc == VCW'(V_ACT));
    end

    // delay control by the read latency so it meets its pixel bit
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < RD_LAT; i++)
                ctl_pipe[i] <= CTL_IDLE;
        end else begin
            ctl_pipe[0] <= ctl_now;
            for (int i = 1; i < RD_LAT; i++)
                ctl_pipe[i] <= ctl_pipe[i-1];
        end
    end

    always_comb ctl_at = ctl_pipe[RD_LAT-1];

    // registered port stage with blanking
    always_ff @(posedge clk) begin
        if (rst) begin
            hsync_n     <= 1'b1;
            vsync_n     <= 1'b1;
            frame_start <= 1'b0;
            out_vis     <= 1'b0;
            red         <= '0;
            green       <= '0;
            blue        <= '0;
        end else begin
            hsync_n     <= ctl_at.hs_n;
            vsync_n     <= ctl_at.vs_n;
            frame_start <= ctl_at.fstart;
            out_vis     <= ctl_at.vis;
            red         <= (ctl_at.vis && pix_bit) ? '1 : '0;
            green       <= (ctl_at.vis && pix_bit) ? '1 : '0;
            blue        <= (ctl_at.vis && pix_bit) ? '1 : '0;
        end
    end

endmodule

// File: rtl/mvga_scan_chk.sv
module mvga_scan_chk
    import mvga_pkg::*;
#(
    parameter int H_TOT   = 800,
    parameter int HCW     = 10,
    parameter int AW      = 15,
    parameter int WORDS   = 19200,
    parameter int COLOR_W = 4
) (
    input logic               clk,
    input logic               rst,
    input logic [HCW-1:0]     hc,
    input phase_t             hph,
    input phase_t             vph,
    input logic               rd_en,
    input logic [AW-1:0]      rd_addr,
    input logic               frame_start,
    input logic               out_vis,
    input logic [COLOR_W-1:0] red,
    input logic [COLOR_W-1:0] green,
    input logic [COLOR_W-1:0] blue
);

    p_line_wrap_r1: assert property (@(posedge clk) disable iff (rst)
        (hc == HCW'(H_TOT - 1)) |=> (hc == '0));

    p_fetch_in_view_r3: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> (hph == PH_VIS && vph == PH_VIS));

    p_addr_range_r3: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> (int'(rd_addr) < WORDS));

    p_white_full_r5: assert property (@(posedge clk) disable iff (rst)
        (red != '0) |-> (red == '1 && green == '1 && blue == '1));

    p_black_blank_r6: assert property (@(posedge clk) disable iff (rst)
        !out_vis |-> (red == '0 && green == '0 && blue == '0));

    p_fstart_single_r7: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> !frame_start);

endmodule

bind mono_vga_scan mvga_scan_chk #(
    .H_TOT(H_TOT), .HCW(HCW), .AW(AW), .WORDS(WORDS), .COLOR_W(COLOR_W)
) u_chk (
    .clk(clk), .rst(rst), .hc(hc), .hph(h_ph), .vph(v_ph),
    .rd_en(fb_rd_en), .rd_addr(fb_rd_addr), .frame_start(frame_start),
    .out_vis(out_vis), .red(red), .green(green), .blue(blue)
);

// File: tb/mono_vga_scan_bench.sv
module mono_vga_scan_bench;

    localparam int HA = 32, HF = 2, HS = 4, HB = 6;
    localparam int VA = 6,  VF = 1, VS = 2, VB = 2;
    localparam int WW = 16, LAT = 2, CWD = 4;
    localparam int HT = HA + HF + HS + HB;
    localparam int VT = VA + VF + VS + VB;
    localparam int WPL = HA / WW;
    localparam int AWB = $clog2(WPL * VA);
    localparam int D = LAT + 1;
    localparam int FRAME = HT * VT;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic fb_rd_en;
    logic [AWB-1:0] fb_rd_addr;
    logic [WW-1:0] fb_rd_data;
    logic hsync_n, vsync_n, frame_start;
    logic [CWD-1:0] red, green, blue;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    mono_vga_scan #(
        .H_ACT(HA), .H_FP(HF), .H_SY(HS), .H_BP(HB),
        .V_ACT(VA), .V_FP(VF), .V_SY(VS), .V_BP(VB),
        .WORD_W(WW), .RD_LAT(LAT), .COLOR_W(CWD)
    ) u_mono_vga_scan (
        .clk(clk), .rst(rst),
        .fb_rd_en(fb_rd_en), .fb_rd_addr(fb_rd_addr), .fb_rd_data(fb_rd_data),
        .hsync_n(hsync_n), .vsync_n(vsync_n),
        .red(red), .green(green), .blue(blue), .frame_start(frame_start)
    );

    function automatic logic [WW-1:0] pat(input int a);
        int v;
        v = a * 40503 + 23100;
        return WW'(v) ^ WW'(a << 7);
    endfunction

    // bench RAM with LAT clocks of read latency
    logic [WW-1:0] ram_s1;
    always_ff @(posedge clk) begin
        ram_s1     <= pat(int'(fb_rd_addr));
        fb_rd_data <= ram_s1;
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic chk_idle(input string req);
        chk(req, "hsync_n idle", 32'(hsync_n), 32'd1);
        chk(req, "vsync_n idle", 32'(vsync_n), 32'd1);
        chk(req, "rgb idle", 32'({red, green, blue}), 32'd0);
        chk(req, "frame_start idle", 32'(frame_start), 32'd0);
    endtask

    // n = clock edges since reset release; counters hold position n
    task automatic check_cycle(input int n);
        int h, v, q, hh, vv, a;
        logic bitv, ev;
        h = n % HT;
        v = (n / HT) % VT;
        ev = (h < HA) && (v < VA) && (h % WW == 0);
        chk("R3", "rd_en", 32'(fb_rd_en), 32'(ev));
        if (ev) chk("R3", "rd_addr", 32'(fb_rd_addr), 32'(v * WPL + h / WW));
        if (n < D) begin
            chk_idle("R8");
        end else begin
            q  = n - D;
            hh = q % HT;
            vv = (q / HT) % VT;
            chk("R1", "hsync_n", 32'(hsync_n),
                32'(!(hh >= HA + HF && hh < HA + HF + HS)));
            chk("R2", "vsync_n", 32'(vsync_n),
                32'(!(vv >= VA + VF && vv < VA + VF + VS)));
            chk("R7", "frame_start", 32'(frame_start), 32'(hh == 0 && vv == VA));
            if (hh < HA && vv < VA) begin
                a = vv * WPL + hh / WW;
                bitv = pat(a)[WW - 1 - hh % WW];
                // R4 bit order and latency, R5 colour mapping
                chk("R4 R5", "rgb", 32'({red, green, blue}),
                    bitv ? 32'({3 * CWD{1'b1}}) : 32'd0);
            end else begin
                chk("R6", "blank rgb", 32'({red, green, blue}), 32'd0);
            end
        end
    endtask

    task automatic run(input int cycles);
        for (int n = 1; n <= cycles; n++) begin
            @(posedge clk);
            @(negedge clk);
            check_cycle(n);
        end
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk_idle("R9");
        rst = 1'b0;
        check_cycle(0);
        run(2 * FRAME + 100);
        // reset in the middle of a frame
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk_idle("R9");
        @(posedge clk);
        @(negedge clk);
        chk_idle("R9");
        rst = 1'b0;
        check_cycle(0);
        run(3 * FRAME);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule